// File: doc/BRIEF.md
# Configurable-Access Register Field

A single control/status register field whose bus write behaviour, read side effect and read legality are all fixed by one elaboration-time mode parameter. A register block instantiates one cell per field, wires the decoded write strobe, write data and per-bit write mask, the decoded read strobe, and, where the hardware must update the field, a load strobe with load data. The field value is always visible to the hardware on `field_q`.

A read is answered one clock after the read strobe. The response carries the value the field held before that read's own side effect. A mode that clears or sets the field on read applies the new value on the same edge that registers the response. Write-only modes answer every read with an error flag and zero data, and leave the field untouched.

When strobes collide, a bus write wins over a hardware load and over a read side effect in the same cycle. The mask limits every write to the bits whose mask bit is 1, and this includes the modes that force the whole field to a constant.

Top module: `csr_field_cell`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `field_q` equals the `INIT` parameter, and `rd_data` and `rd_err` are 0.
- R2: Bitwise write modes, with `MODE` codes 0 to 3. In code 0 a written 1 sets its bit. In code 1 a written 0 sets its bit. In code 2 a written 1 clears its bit. In code 3 a written 0 clears its bit. Every other written value leaves its bit unchanged.
- R3: Constant write modes, with `MODE` codes 6 to 11. In codes 6, 9 and 10 a write clears the field. In codes 7, 8 and 11 a write sets the field. The write data is ignored.
- R4: Load modes, with `MODE` codes 4, 5 and 14. A write stores `wr_data` unchanged.
- R5: Toggle modes. In `MODE` code 12 a written 1 inverts its bit. In code 13 a written 0 inverts its bit. Reads have no side effect in either mode.
- R6: In every mode, a bit whose `wr_mask` bit is 0 keeps its value during a write.
- R7: A read strobe without a write in the same cycle does two things. On the next edge `rd_data` shows the field value held before the read. In `MODE` codes 0, 1, 4 and 8 the field becomes all zeros on that same edge. After a cycle with no read, `rd_data` is 0.
- R8: A read strobe without a write in the same cycle sets the field to all ones on the next edge in `MODE` codes 2, 3, 5 and 9. In codes 6, 7 and 12 to 14 a read leaves the field unchanged.
- R9: In `MODE` codes 10 and 11 a read gives `rd_err` high for exactly one cycle, one clock after the strobe, with `rd_data` 0 and no change to the field. In all other modes `rd_err` stays 0.
- R10: In `MODE` code 14, `hw_load` without a bus write loads `hw_data` into the field on the next edge. In all other modes `hw_load` has no effect.
- R11: When a bus write occurs in the same cycle as a hardware load or a read, the write result is what the field holds next. The read response is still returned.
- R12: With no strobe active, the field holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | WIDTH | Bus write data |
| wr_mask | input | WIDTH | Per-bit write enable |
| rd_en | input | 1 | Bus read strobe |
| rd_data | output | WIDTH | Read response data, one cycle after `rd_en` |
| rd_err | output | 1 | Read error response, one cycle after `rd_en` |
| hw_load | input | 1 | Hardware load strobe |
| hw_data | input | WIDTH | Hardware load value |
| field_q | output | WIDTH | Current field value |

## Verification
The hardest situation to reach is a collision. A write must meet a read side effect or a hardware load in the same cycle, and the field must hold a value that tells the winner apart from the loser. The stimulus first drives the field to a known non-constant pattern. It then raises the write strobe together with the read or load strobe, using data chosen to differ from both all-zeros and all-ones. Every mode is instantiated side by side and fed the same sequence, so each collision is observed under every access type.

// File: rtl/csr_field_pkg.sv
package csr_field_pkg;

   // Access types; the numeric codes are part of the block's interface.
   typedef enum logic [3:0] {
      FM_SET1_RDCLR   = 4'd0,
      FM_SET0_RDCLR   = 4'd1,
      FM_CLR1_RDSET   = 4'd2,
      FM_CLR0_RDSET   = 4'd3,
      FM_LOAD_RDCLR   = 4'd4,
      FM_LOAD_RDSET   = 4'd5,
      FM_WRZERO       = 4'd6,
      FM_WRONES       = 4'd7,
      FM_WRONES_RDCLR = 4'd8,
      FM_WRZERO_RDSET = 4'd9,
      FM_WONLY_ZERO   = 4'd10,
      FM_WONLY_ONES   = 4'd11,
      FM_FLIP1        = 4'd12,
      FM_FLIP0        = 4'd13,
      FM_LOAD_HWLD    = 4'd14
   } field_mode_e;

   typedef enum logic [1:0] {
      RD_KEEP,
      RD_CLEAR,
      RD_SET
   } rd_effect_e;

   function automatic rd_effect_e rd_effect_of(field_mode_e m);
      case (m)
         FM_SET1_RDCLR, FM_SET0_RDCLR,
         FM_LOAD_RDCLR, FM_WRONES_RDCLR: return RD_CLEAR;
         FM_CLR1_RDSET, FM_CLR0_RDSET,
         FM_LOAD_RDSET, FM_WRZERO_RDSET: return RD_SET;
         default:                        return RD_KEEP;
      endcase
   endfunction

   function automatic bit rd_is_error(field_mode_e m);
      return (m == FM_WONLY_ZERO) || (m == FM_WONLY_ONES);
   endfunction

   function automatic bit hw_can_load(field_mode_e m);
      return m == FM_LOAD_HWLD;
   endfunction

endpackage

// File: rtl/csr_field_wr.sv
module csr_field_wr
   import csr_field_pkg::*;
#(
   parameter int          WIDTH = 8,
   parameter field_mode_e MODE  = FM_LOAD_HWLD
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [WIDTH-1:0] wr_mask,
   output logic [WIDTH-1:0] wr_next
);

   localparam logic [WIDTH-1:0] ALL_ONES  = '1;
   localparam logic [WIDTH-1:0] ALL_ZEROS = '0;

   logic [WIDTH-1:0] raw;

   generate
      if (MODE == FM_SET1_RDCLR) begin : g_set1
         assign raw = cur | wr_data;
      end else if (MODE == FM_SET0_RDCLR) begin : g_set0
         assign raw = cur | ~wr_data;
      end else if (MODE == FM_CLR1_RDSET) begin : g_clr1
         assign raw = cur & ~wr_data;
      end else if (MODE == FM_CLR0_RDSET) begin : g_clr0
         assign raw = cur & wr_data;
      end else if (MODE == FM_FLIP1) begin : g_flip1
         assign raw = cur ^ wr_data;
      end else if (MODE == FM_FLIP0) begin : g_flip0
         assign raw = cur ^ ~wr_data;
      end else if (MODE == FM_LOAD_RDCLR || MODE == FM_LOAD_RDSET ||
                   MODE == FM_LOAD_HWLD) begin : g_load
         assign raw = wr_data;
      end else if (MODE == FM_WRONES || MODE == FM_WRONES_RDCLR ||
                   MODE == FM_WONLY_ONES) begin : g_ones
         logic [WIDTH-1:0] unused_wd;
         assign unused_wd = wr_data;
         assign raw = ALL_ONES;
      end else begin : g_zero
         logic [WIDTH-1:0] unused_wd;
         assign unused_wd = wr_data;
         assign raw = ALL_ZEROS;
      end
   endgenerate

   // Unmasked bits pass the current value through.
   assign wr_next = (raw & wr_mask) | (cur & ~wr_mask);

endmodule

// File: rtl/csr_field_rd.sv
module csr_field_rd
   import csr_field_pkg::*;
#(
   parameter int          WIDTH = 8,
   parameter field_mode_e MODE  = FM_LOAD_HWLD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_err,
   output logic             fx_en,
   output logic [WIDTH-1:0] fx_val
);

   localparam rd_effect_e FX  = rd_effect_of(MODE);
   localparam bit         ERR = rd_is_error(MODE);

   generate
      if (ERR) begin : g_err_resp
         logic [WIDTH-1:0] unused_cur;
         assign unused_cur = cur;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data <= '0;
               rd_err  <= 1'b0;
            end else begin
               rd_data <= '0;
               rd_err  <= rd_en;
            end
         end
      end else begin : g_data_resp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data <= '0;
               rd_err  <= 1'b0;
            end else begin
               rd_data <= rd_en ? cur : '0;
               rd_err  <= 1'b0;
            end
         end
      end

      if (FX == RD_KEEP) begin : g_fx_none
         assign fx_en  = 1'b0;
         assign fx_val = '0;
      end else if (FX == RD_SET) begin : g_fx_set
         assign fx_en  = rd_en;
         assign fx_val = '1;
      end else begin : g_fx_clr
         assign fx_en  = rd_en;
         assign fx_val = '0;
      end
   endgenerate

endmodule

// File: rtl/csr_field_cell.sv
module csr_field_cell
   import csr_field_pkg::*;
#(
   parameter int               WIDTH = 8,
   parameter logic [WIDTH-1:0] INIT  = '0,
   parameter field_mode_e      MODE  = FM_LOAD_HWLD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [WIDTH-1:0] wr_mask,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_err,
   input  logic             hw_load,
   input  logic [WIDTH-1:0] hw_data,
   output logic [WIDTH-1:0] field_q
);

   localparam bit HW_OK = hw_can_load(MODE);

   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("csr_field_cell: WIDTH must lie in 1..64");
      end
   endgenerate

   logic [WIDTH-1:0] wr_next;
   logic             fx_en;
   logic [WIDTH-1:0] fx_val;
   logic             hw_take;
   logic [WIDTH-1:0] d_next;

   csr_field_wr #(.WIDTH(WIDTH), .MODE(MODE)) u_wr (
      .cur     (field_q),
      .wr_data (wr_data),
      .wr_mask (wr_mask),
      .wr_next (wr_next)
   );

   csr_field_rd #(.WIDTH(WIDTH), .MODE(MODE)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .cur     (field_q),
      .rd_data (rd_data),
      .rd_err  (rd_err),
      .fx_en   (fx_en),
      .fx_val  (fx_val)
   );

   generate
      if (HW_OK) begin : g_hw_path
         assign hw_take = hw_load;
      end else begin : g_hw_none
         logic [WIDTH:0] unused_hw;
         assign unused_hw = {hw_load, hw_data};
         assign hw_take   = 1'b0;
      end
   endgenerate

   // Priority: bus write, then hardware load, then read side effect.
   always_comb begin
      if (wr_en)        d_next = wr_next;
      else if (hw_take) d_next = hw_data;
      else if (fx_en)   d_next = fx_val;
      else              d_next = field_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) field_q <= INIT;
      else        field_q <= d_next;
   end

endmodule

// File: rtl/csr_field_cell_chk.sv
module csr_field_cell_chk
   import csr_field_pkg::*;
#(
   parameter int               WIDTH = 8,
   parameter logic [WIDTH-1:0] INIT  = '0,
   parameter field_mode_e      MODE  = FM_LOAD_HWLD
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] wr_mask,
   input logic             rd_en,
   input logic [WIDTH-1:0] rd_data,
   input logic             rd_err,
   input logic             hw_load,
   input logic [WIDTH-1:0] hw_data,
   input logic [WIDTH-1:0] field_q
);

   localparam rd_effect_e FX  = rd_effect_of(MODE);
   localparam bit         ERR = rd_is_error(MODE);

   // R1
   a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (field_q == INIT && !rd_err && rd_data == '0));

   a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((field_q & ~$past(wr_mask)) == ($past(field_q) & ~$past(wr_mask))));

   a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !rd_en && !hw_load) |=> $stable(field_q));

   a_r7_no_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0 && !rd_err));

   a_r9_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rd_err == ERR));

   generate
      if (!ERR) begin : g_chk_data
         a_r7_prior_value: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> (rd_data == $past(field_q)));
      end else begin : g_chk_err
         a_r9_no_fx: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !wr_en && !hw_load) |=> ($stable(field_q) && rd_data == '0));
      end

      if (FX == RD_CLEAR) begin : g_chk_clr
         a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !wr_en) |=> (field_q == '0));
      end else if (FX == RD_SET) begin : g_chk_set
         a_r8_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !wr_en) |=> (field_q == {WIDTH{1'b1}}));
      end

      if (hw_can_load(MODE)) begin : g_chk_hw
         a_r10_hw_load: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_load && !wr_en) |=> (field_q == $past(hw_data)));
         a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hw_load) |=> (field_q ==
               (($past(wr_data) & $past(wr_mask)) | ($past(field_q) & ~$past(wr_mask)))));
      end else begin : g_chk_nohw
         a_r10_hw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_load && !wr_en && !rd_en) |=> $stable(field_q));
      end
   endgenerate

endmodule

bind csr_field_cell csr_field_cell_chk #(
   .WIDTH (WIDTH),
   .INIT  (INIT),
   .MODE  (MODE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .wr_mask (wr_mask),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .rd_err  (rd_err),
   .hw_load (hw_load),
   .hw_data (hw_data),
   .field_q (field_q)
);

// File: tb/tb_csr_field_cell.sv
`timescale 1ns/1ps
module tb_csr_field_cell;
   import csr_field_pkg::*;

   localparam int         W    = 8;
   localparam int         NM   = 15;
   localparam logic [7:0] INIT = 8'hA5;
   localparam int         NV   = 18;

   // Vector layout: {wr, rd, hw, wr_data[8], wr_mask[8], hw_data[8]}
   localparam logic [26:0] VEC [NV] = '{
      {3'b000, 8'h00, 8'h00, 8'h00},   // idle
      {3'b100, 8'h3C, 8'hFF, 8'h00},   // full write
      {3'b010, 8'h00, 8'h00, 8'h00},   // read
      {3'b100, 8'hF0, 8'h0F, 8'h00},   // masked write
      {3'b010, 8'h00, 8'h00, 8'h00},   // read
      {3'b001, 8'h00, 8'h00, 8'h5A},   // hw load
      {3'b100, 8'h00, 8'hFF, 8'h00},   // write zeros
      {3'b010, 8'h00, 8'h00, 8'h00},   // read
      {3'b100, 8'hFF, 8'hFF, 8'h00},   // write ones
      {3'b101, 8'h12, 8'hFF, 8'hEE},   // write + hw load
      {3'b110, 8'h81, 8'hFF, 8'h00},   // write + read
      {3'b010, 8'h00, 8'h00, 8'h00},   // read
      {3'b000, 8'h00, 8'h00, 8'h00},   // idle
      {3'b100, 8'h55, 8'h33, 8'h00},   // masked write
      {3'b001, 8'h00, 8'h00, 8'hC3},   // hw load
      {3'b011, 8'h00, 8'h00, 8'h7E},   // read + hw load
      {3'b010, 8'h00, 8'h00, 8'h00},   // read
      {3'b100, 8'hAA, 8'hFF, 8'h00}    // full write
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0, hw_load = 1'b0;
   logic [W-1:0] wr_data = '0, wr_mask = '0, hw_data = '0;

   logic [W-1:0] q_a   [NM];
   logic [W-1:0] rd_a  [NM];
   logic         err_a [NM];
   logic [W-1:0] exp_q [NM];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   for (genvar g = 0; g < NM; g++) begin : g_mode
      localparam logic [3:0] MC = 4'(g);
      csr_field_cell #(.WIDTH(W), .INIT(INIT), .MODE(field_mode_e'(MC))) dut (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_data (wr_data),
         .wr_mask (wr_mask),
         .rd_en   (rd_en),
         .rd_data (rd_a[g]),
         .rd_err  (err_a[g]),
         .hw_load (hw_load),
         .hw_data (hw_data),
         .field_q (q_a[g])
      );
   end

   function automatic bit is_rc(field_mode_e m);
      return m inside {FM_SET1_RDCLR, FM_SET0_RDCLR, FM_LOAD_RDCLR, FM_WRONES_RDCLR};
   endfunction
   function automatic bit is_rs(field_mode_e m);
      return m inside {FM_CLR1_RDSET, FM_CLR0_RDSET, FM_LOAD_RDSET, FM_WRZERO_RDSET};
   endfunction
   function automatic bit is_wo(field_mode_e m);
      return m inside {FM_WONLY_ZERO, FM_WONLY_ONES};
   endfunction

   // Reference behaviour written from the requirements.
   function automatic logic [7:0] ref_next(field_mode_e m, logic [7:0] cur, logic wr,
         logic rd, logic hw, logic [7:0] wd, logic [7:0] mk, logic [7:0] hd);
      logic [7:0] tgt;
      case (m)
         FM_SET1_RDCLR:   tgt = wd;
         FM_SET0_RDCLR:   tgt = ~wd;
         FM_CLR1_RDSET,
         FM_CLR0_RDSET:   tgt = 8'h00;
         FM_LOAD_RDCLR, FM_LOAD_RDSET, FM_LOAD_HWLD: tgt = wd;
         FM_WRZERO, FM_WRZERO_RDSET, FM_WONLY_ZERO:  tgt = 8'h00;
         FM_WRONES, FM_WRONES_RDCLR, FM_WONLY_ONES:  tgt = 8'hFF;
         FM_FLIP1:        tgt = ~cur;
         default:         tgt = ~cur;
      endcase
      if (wr) begin
         for (int b = 0; b < 8; b++) begin
            logic hit;
            case (m)
               FM_SET1_RDCLR, FM_CLR1_RDSET, FM_FLIP1: hit = wd[b];
               FM_SET0_RDCLR, FM_CLR0_RDSET, FM_FLIP0: hit = !wd[b];
               default:                                hit = 1'b1;
            endcase
            if (mk[b] && hit) cur[b] = tgt[b];
         end
         return cur;
      end
      if (hw && m == FM_LOAD_HWLD) return hd;
      if (rd && is_rc(m)) return 8'h00;
      if (rd && is_rs(m)) return 8'hFF;
      return cur;
   endfunction

   function automatic string tag_of(field_mode_e m, logic wr, logic rd, logic hw,
                                    logic [7:0] mk);
      if (wr && (hw || rd)) return "R11";
      if (wr && mk != 8'hFF) return "R6";
      if (wr) begin
         if (m inside {FM_SET1_RDCLR, FM_SET0_RDCLR, FM_CLR1_RDSET, FM_CLR0_RDSET})
            return "R2";
         if (m inside {FM_LOAD_RDCLR, FM_LOAD_RDSET, FM_LOAD_HWLD}) return "R4";
         if (m inside {FM_FLIP1, FM_FLIP0}) return "R5";
         return "R3";
      end
      if (rd) begin
         if (is_wo(m)) return "R9";
         if (is_rs(m)) return "R8";
         return "R7";
      end
      if (hw) return "R10";
      return "R12";
   endfunction

   task automatic check(int m, string tag, logic [7:0] eq, logic [7:0] erd, logic eerr);
      checks++;
      if (q_a[m] !== eq || rd_a[m] !== erd || err_a[m] !== eerr) begin
         fails++;
         $display("FAIL %s mode=%0d q=%h rd=%h err=%b expected q=%h rd=%h err=%b",
                  tag, m, q_a[m], rd_a[m], err_a[m], eq, erd, eerr);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic run_vec(logic [26:0] v);
      logic wr, rd, hw;
      logic [7:0] wd, mk, hd;
      logic [7:0] erd [NM];
      logic       eerr [NM];
      {wr, rd, hw, wd, mk, hd} = v;
      wr_en = wr; rd_en = rd; hw_load = hw;
      wr_data = wd; wr_mask = mk; hw_data = hd;
      for (int m = 0; m < NM; m++) begin
         field_mode_e fm = field_mode_e'(m[3:0]);
         eerr[m]  = rd && is_wo(fm);
         erd[m]   = (rd && !is_wo(fm)) ? exp_q[m] : 8'h00;
         exp_q[m] = ref_next(fm, exp_q[m], wr, rd, hw, wd, mk, hd);
      end
      @(posedge clk);
      #1;
      for (int m = 0; m < NM; m++)
         check(m, tag_of(field_mode_e'(m[3:0]), wr, rd, hw, mk), exp_q[m], erd[m], eerr[m]);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: state while in reset
      repeat (3) @(negedge clk);
      for (int m = 0; m < NM; m++) begin
         exp_q[m] = INIT;
         check(m, "R1", INIT, 8'h00, 1'b0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk
      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R12: a second idle cycle after activity
      run_vec({3'b000, 8'h00, 8'h00, 8'h00});

      // R1: reset in the middle of operation restores INIT at once
      rst_n = 1'b0;
      #1;
      for (int m = 0; m < NM; m++) begin
         exp_q[m] = INIT;
         check(m, "R1", INIT, 8'h00, 1'b0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: two back-to-back reads, error each cycle, field untouched
      run_vec({3'b010, 8'h00, 8'h00, 8'h00});
      run_vec({3'b010, 8'h00, 8'h00, 8'h00});
      // R9: error flag drops when reads stop
      run_vec({3'b000, 8'h00, 8'h00, 8'h00});
      // R6: zero mask write changes nothing
      run_vec({3'b100, 8'h0F, 8'h00, 8'h00});
      // R11: write + read + hw load together
      run_vec({3'b111, 8'h96, 8'hF0, 8'h11});

      wr_en = 1'b0; rd_en = 1'b0; hw_load = 1'b0;
      done = 1'b1;
      summary();
      $finish;
   end

endmodule